// File: doc/BRIEF.md
# Byte-Wide Data EEPROM Controller with Write Unlock

This block lets a CPU read and write a small on-chip byte store through four byte-wide registers on a simple register bus. Each access is a single-cycle strobe. Reads of the store take one clock and land in the data register. Writes are deliberately hard to start by accident. The CPU must first arm the block by writing the key pair 0x55 and then 0xAA to the key register. The next control-register write must then request a write with write enable set. The write runs for a fixed number of clocks. During that time the target address and byte are held internally, and it can be cancelled.

Register offsets on `bus_addr`: 0 = control, 1 = address, 2 = data, 3 = key. `bus_rdata` always shows the register selected by `bus_addr`, whether or not `bus_sel` is high. A cycle counts as an access only when `bus_sel` is high.

The control register fields are: bit 7 = space select (1 selects the program space, which is not served here), bit 3 = write-error flag, bit 2 = write enable, bit 1 = write busy/start, bit 0 = read busy/start. Bits 6:4 are spare.

Three state machines do the work:
- Key machine: states K_IDLE, K_HALF and K_ARMED.
  - K_IDLE or K_ARMED moves to K_HALF when 0x55 is written to the key register.
  - K_HALF moves to K_ARMED when the next access writes 0xAA to the key register.
  - Any other access sends the machine to K_IDLE.
- Read machine: states R_IDLE and R_FETCH.
  - R_IDLE moves to R_FETCH when a read is accepted.
  - R_FETCH always returns to R_IDLE after one clock.
- Write machine: states W_IDLE and W_RUN.
  - W_IDLE moves to W_RUN when a write starts.
  - W_RUN returns to W_IDLE either when the count finishes (the byte is committed) or when the write is cancelled (the byte is untouched).

Top module: `nvb_ctrl`

## Requirements
- R1: After reset, the control, address, data and key registers read 0x00, and every byte of the store reads 0xFF.
- R2: A control write with bit 0 = 1 and bit 7 = 0 sets bit 0 for exactly one cycle. After that cycle, the data register holds the byte at the current address and bit 0 reads 0.
- R3: Writing 0 to bit 0 or bit 1 never clears them. Bits 6:4 of the control register read 0, and the key register reads 0x00.
- R4: A write starts only if the last two accesses before the starting control write were 0x55 and then 0xAA to the key register. Otherwise bit 1 stays 0 and the store is unchanged.
- R5: A write request whose control write has bit 2 = 0 is ignored.
- R6: Bit 1 reads 1 for exactly WR_CYCLES cycles after a write starts. The byte written is the data and address held when the write started, even if those registers change during the write.
- R7: A write request made while a write is running is ignored. The running write ends on time and does nothing else.
- R8: A one-cycle pulse on `abort_i` during a write ends it in that cycle. The byte is left unchanged, bit 1 clears and bit 3 sets.
- R9: A control write with bit 2 = 0 during a write cancels it in the same way as R8.
- R10: Bit 3 clears when a write completes normally or when software writes 0 to it. Writing 1 to bit 3 never sets it.
- R11: With bit 7 = 1 in the control write, a read or write request does nothing.
- R12: Arming is used up by the write-start attempt. A second start without a new key pair is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = register write, 0 = register read |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Contents of the register at `bus_addr` |
| abort_i | input | 1 | Synchronous cancel of a running write |

## Verification
The bench attacks the unlock rule with broken key sequences: a 0x55 followed by another access before the 0xAA, a 0xAA on its own, and a start with no key at all. A design that arms too easily would then modify the store. It retargets the address and data registers and re-requests a write in the middle of a running write. A design that failed to hold its inputs would commit the wrong byte, and one that failed to ignore the new request would commit a second byte. Cancellation is tested both through `abort_i` and by clearing write enable; a design that commits anyway, or leaves the busy bit set, corrupts the store or hangs. The error bit, the read-only spare bits and the exact length of the busy window are checked against a shadow copy of the store kept in the bench.

// File: rtl/nvb_pkg.sv
`timescale 1ns/1ps
package nvb_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        RG_CTRL = 2'd0,
        RG_ADDR = 2'd1,
        RG_DATA = 2'd2,
        RG_KEY  = 2'd3
    } reg_sel_e;

    localparam int B_RD  = 0;
    localparam int B_WR  = 1;
    localparam int B_WEN = 2;
    localparam int B_ERR = 3;
    localparam int B_SEL = 7;

    localparam logic [BYTE_W-1:0] KEY_FIRST  = 8'h55;
    localparam logic [BYTE_W-1:0] KEY_SECOND = 8'hAA;
    localparam logic [BYTE_W-1:0] ERASED     = 8'hFF;

    typedef enum logic [1:0] {K_IDLE, K_HALF, K_ARMED} key_st_e;
    typedef enum logic {W_IDLE, W_RUN} wr_st_e;
    typedef enum logic {R_IDLE, R_FETCH} rd_st_e;
endpackage

// File: rtl/nvb_unlock.sv
`timescale 1ns/1ps
module nvb_unlock
    import nvb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              key_first,
    input  logic              key_second,
    output logic              armed
);
    key_st_e st, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= K_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = K_IDLE;
        unique case (st)
            K_IDLE, K_ARMED: begin
                if (!acc)           nxt = st;
                else if (key_first) nxt = K_HALF;
                else                nxt = K_IDLE;
            end
            K_HALF: begin
                if (!acc)            nxt = K_HALF;
                else if (key_first)  nxt = K_HALF;
                else if (key_second) nxt = K_ARMED;
                else                 nxt = K_IDLE;
            end
            default: nxt = K_IDLE;
        endcase
    end

    always_comb armed = (st == K_ARMED);
endmodule

// File: rtl/nvb_wr_seq.sv
`timescale 1ns/1ps
module nvb_wr_seq
    import nvb_pkg::*;
#(
    parameter int CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cancel,
    input  logic err_clr,
    output logic busy,
    output logic commit,
    output logic err
);
    localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;

    wr_st_e        st, nxt;
    logic [CW-1:0] cnt;
    logic          last;

    always_comb last = (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= W_IDLE;
            cnt <= '0;
            err <= 1'b0;
        end else begin
            st <= nxt;
            if (st == W_IDLE && start)        cnt <= CW'(CYC - 1);
            else if (st == W_RUN && !last)    cnt <= cnt - 1'b1;
            if (st == W_RUN && cancel)        err <= 1'b1;
            else if (st == W_RUN && last)     err <= 1'b0;
            else if (err_clr)                 err <= 1'b0;
        end
    end

    always_comb begin
        nxt    = st;
        commit = 1'b0;
        busy   = 1'b0;
        unique case (st)
            W_IDLE: begin
                if (start) nxt = W_RUN;
            end
            W_RUN: begin
                busy = 1'b1;
                if (cancel)    nxt = W_IDLE;
                else if (last) begin
                    nxt    = W_IDLE;
                    commit = 1'b1;
                end
            end
            default: nxt = W_IDLE;
        endcase
    end
endmodule

// File: rtl/nvb_store.sv
`timescale 1ns/1ps
module nvb_store
    import nvb_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [BYTE_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_comb rdata = mem[raddr];
endmodule

// File: rtl/nvb_ctrl.sv
`timescale 1ns/1ps
module nvb_ctrl
    import nvb_pkg::*;
#(
    parameter int WR_CYCLES = 16,
    parameter int AW        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              abort_i
);
    logic              ctrl_w, data_w, addr_w, key_first, key_second;
    logic              armed, wr_busy, wr_commit, wr_err, rd_busy;
    logic              rd_go, wr_go, wr_cancel, err_clr;
    logic              sel_q, wen_q;
    logic [BYTE_W-1:0] addr_q, data_q, lat_data, mem_rd;
    logic [AW-1:0]     lat_addr;
    logic              unused_spare;
    rd_st_e            rd_st, rd_nxt;

    always_comb begin
        ctrl_w     = bus_sel && bus_we && (bus_addr == RG_CTRL);
        addr_w     = bus_sel && bus_we && (bus_addr == RG_ADDR);
        data_w     = bus_sel && bus_we && (bus_addr == RG_DATA);
        key_first  = bus_sel && bus_we && (bus_addr == RG_KEY) && (bus_wdata == KEY_FIRST);
        key_second = bus_sel && bus_we && (bus_addr == RG_KEY) && (bus_wdata == KEY_SECOND);
        rd_go      = ctrl_w && bus_wdata[B_RD] && !bus_wdata[B_SEL] && (rd_st == R_IDLE);
        wr_go      = ctrl_w && bus_wdata[B_WR] && !bus_wdata[B_SEL] && bus_wdata[B_WEN]
                     && armed && !wr_busy;
        wr_cancel  = abort_i || (ctrl_w && !bus_wdata[B_WEN]);
        err_clr    = ctrl_w && !bus_wdata[B_ERR];
        unused_spare = ^bus_wdata[6:4];
    end

    nvb_unlock u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (bus_sel),
        .key_first (key_first),
        .key_second(key_second),
        .armed     (armed)
    );

    nvb_wr_seq #(.CYC(WR_CYCLES)) u_wseq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (wr_go),
        .cancel (wr_cancel),
        .err_clr(err_clr),
        .busy   (wr_busy),
        .commit (wr_commit),
        .err    (wr_err)
    );

    nvb_store #(.AW(AW)) u_mem (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (wr_commit),
        .waddr(lat_addr),
        .wdata(lat_data),
        .raddr(addr_q[AW-1:0]),
        .rdata(mem_rd)
    );

    // read machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) rd_st <= R_IDLE;
        else        rd_st <= rd_nxt;
    end

    // read machine: next state and outputs
    always_comb begin
        rd_nxt  = rd_st;
        rd_busy = 1'b0;
        unique case (rd_st)
            R_IDLE:  if (rd_go) rd_nxt = R_FETCH;
            R_FETCH: begin
                rd_busy = 1'b1;
                rd_nxt  = R_IDLE;
            end
            default: rd_nxt = R_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= 1'b0;
            wen_q    <= 1'b0;
            addr_q   <= '0;
            data_q   <= '0;
            lat_addr <= '0;
            lat_data <= '0;
        end else begin
            if (ctrl_w) begin
                sel_q <= bus_wdata[B_SEL];
                wen_q <= bus_wdata[B_WEN];
            end
            if (addr_w) addr_q <= bus_wdata;
            if (rd_busy)     data_q <= mem_rd;
            else if (data_w) data_q <= bus_wdata;
            if (wr_go) begin
                lat_addr <= addr_q[AW-1:0];
                lat_data <= data_q;
            end
        end
    end

    always_comb begin
        unique case (bus_addr)
            RG_CTRL: bus_rdata = {sel_q, 3'b000, wr_err, wen_q, wr_busy, rd_busy};
            RG_ADDR: bus_rdata = addr_q;
            RG_DATA: bus_rdata = data_q;
            RG_KEY:  bus_rdata = '0;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/nvb_ctrl_chk.sv
`timescale 1ns/1ps
module nvb_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       abort_i,
    input logic [1:0] bus_addr,
    input logic [7:0] bus_rdata,
    input logic       rd_busy,
    input logic       wr_busy,
    input logic       armed,
    input logic       wen_q,
    input logic       sel_q,
    input logic       wr_err
);
    // R2
    rd_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_busy |=> !rd_busy);

    // R3
    spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd0) |-> (bus_rdata[6:4] == 3'b000));

    // R3
    key_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 2'd3) |-> (bus_rdata == 8'h00));

    // R4
    start_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_busy) |-> $past(armed));

    // R5
    start_needs_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_busy) |-> wen_q);

    // R8
    abort_ends_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_i && wr_busy) |=> (!wr_busy && wr_err));

    // R11
    read_space_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_busy) |-> !sel_q);
endmodule

bind nvb_ctrl nvb_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort_i  (abort_i),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .rd_busy  (rd_busy),
    .wr_busy  (wr_busy),
    .armed    (armed),
    .wen_q    (wen_q),
    .sel_q    (sel_q),
    .wr_err   (wr_err)
);

// File: tb/sim_nvb_ctrl.sv
`timescale 1ns/1ps
module sim_nvb_ctrl;
    localparam int CYC = 16;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_we = 1'b0, abort_i = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    int   n_run = 0, n_fail = 0, cyc = 0;
    bit   finished = 1'b0;
    logic [7:0] ref_mem [256];
    bit   ref_err = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    nvb_ctrl #(.WR_CYCLES(CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .abort_i(abort_i)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_sel = 1'b1; bus_we = 1'b1;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_sel = 1'b1; bus_we = 1'b0;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic unlock();
        wr(2'd3, 8'h55);
        wr(2'd3, 8'hAA);
    endtask

    function automatic logic [7:0] exp_ctrl(input bit err, input bit wen, input bit busy);
        return {4'b0000, err, wen, busy, 1'b0};
    endfunction

    task automatic check_byte(input logic [7:0] a, input string tag);
        logic [7:0] v;
        wr(2'd1, a);
        wr(2'd0, 8'h0D);
        @(negedge clk);
        peek(2'd2, v);
        chk(v == ref_mem[a], tag, v, ref_mem[a]);
    endtask

    // wait for the busy bit to drop; returns cycles it was seen high
    task automatic wait_idle(input int c0, output int len);
        logic [7:0] v;
        len = -1;
        for (int k = 0; k < 200; k++) begin
            peek(2'd0, v);
            if (!v[1]) begin
                len = cyc - c0;
                break;
            end
            @(negedge clk);
        end
    endtask

    // mode 0: normal with mid-write disturbance, 1: abort pin, 2: wen cleared
    task automatic do_write(input logic [7:0] a, input logic [7:0] d, input int mode);
        logic [7:0] v;
        int c0, len;
        wr(2'd1, a);
        wr(2'd2, d);
        wr(2'd0, 8'h0C);
        unlock();
        wr(2'd0, 8'h0E);
        c0 = cyc;
        if (mode == 0) begin
            wr(2'd1, a ^ 8'h5A);      // R6 retarget during write
            wr(2'd2, ~d);
            wr(2'd0, 8'h0C);          // R3 writing 0 to bit 1 does not clear it
            peek(2'd0, v);
            chk(v[1] == 1'b1, "R3 busy bit survives sw 0", v, 8'h02);
            wr(2'd0, 8'h0E);          // R7 second request ignored
            wait_idle(c0, len);
            chk(len == CYC, "R6 busy length", len, CYC);
            ref_mem[a] = d;
            ref_err    = 1'b0;
            peek(2'd0, v);
            chk(v == exp_ctrl(1'b0, 1'b1, 1'b0), "R10 err clear on completion", v, exp_ctrl(1'b0, 1'b1, 1'b0));
            check_byte(a, "R6 latched byte committed");
            if ((a ^ 8'h5A) != a) check_byte(a ^ 8'h5A, "R7 no second write");
        end else begin
            repeat (3) @(negedge clk);
            if (mode == 1) begin
                abort_i = 1'b1;
                @(negedge clk);
                abort_i = 1'b0;
            end else begin
                wr(2'd0, 8'h08);
            end
            peek(2'd0, v);
            chk(v[1] == 1'b0 && v[3] == 1'b1, mode == 1 ? "R8 abort pin" : "R9 wen cleared",
                v, {4'b0, 1'b1, 3'b0});
            ref_err = 1'b1;
            repeat (CYC) @(negedge clk);
            check_byte(a, mode == 1 ? "R8 byte unchanged" : "R9 byte unchanged");
        end
    endtask

    // kinds: 0 no key, 1 key broken by access, 2 wen=0, 3 program space, 4 lone 0xAA
    task automatic bad_write(input logic [7:0] a, input logic [7:0] d, input int kind);
        logic [7:0] v;
        string tag;
        wr(2'd1, a);
        wr(2'd2, d);
        wr(2'd0, 8'h0C);
        unique case (kind)
            0: tag = "R4 no key";
            1: begin tag = "R4 broken key"; wr(2'd3, 8'h55); rd(2'd2, v); wr(2'd3, 8'hAA); end
            2: begin tag = "R5 wen low"; unlock(); end
            3: begin tag = "R11 program space"; unlock(); end
            default: begin tag = "R4 lone second key"; wr(2'd3, 8'hAA); end
        endcase
        wr(2'd0, kind == 2 ? 8'h0A : (kind == 3 ? 8'h8E : 8'h0E));
        peek(2'd0, v);
        chk(v[1] == 1'b0, tag, v[1], 0);
        repeat (CYC + 2) @(negedge clk);
        check_byte(a, tag);
    endtask

    initial begin
        logic [7:0] v;
        int unsigned s;
        int c0, len;
        s = $urandom(32'h5EED_0042);
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int r = 0; r < 4; r++) begin
            peek(2'(r), v);
            chk(v == 8'h00, "R1 register reset", v, 0);
        end
        check_byte(8'h00, "R1 erased byte");
        check_byte(8'hFF, "R1 erased byte");

        // R2 read bit is one cycle wide
        wr(2'd1, 8'h10);
        wr(2'd0, 8'h0D);
        peek(2'd0, v);
        chk(v[0] == 1'b1, "R2 read bit set", v, 8'h01);
        @(negedge clk);
        peek(2'd0, v);
        chk(v[0] == 1'b0, "R2 read bit cleared", v, 0);

        // R3 spare bits and key register read as zero
        wr(2'd0, 8'h78);
        peek(2'd0, v);
        chk(v[6:4] == 3'b000, "R3 spare bits", v, 0);
        wr(2'd3, 8'hAA);
        peek(2'd3, v);
        chk(v == 8'h00, "R3 key reads zero", v, 0);

        // R11 read in program space does nothing
        wr(2'd0, 8'h81);
        peek(2'd0, v);
        chk(v[0] == 1'b0, "R11 read ignored", v, 0);

        // main write paths
        do_write(8'h21, 8'h3C, 0);
        do_write(8'h22, 8'h99, 1);
        // R10 software clear and no software set
        wr(2'd0, 8'h04);
        peek(2'd0, v);
        chk(v[3] == 1'b0, "R10 sw clear", v, 0);
        wr(2'd0, 8'h0C);
        peek(2'd0, v);
        chk(v[3] == 1'b0, "R10 sw cannot set", v, 0);
        ref_err = 1'b0;
        do_write(8'h23, 8'h11, 2);
        wr(2'd0, 8'h04);
        ref_err = 1'b0;

        // R12 arming consumed
        wr(2'd1, 8'h40);
        wr(2'd2, 8'h77);
        wr(2'd0, 8'h0C);
        unlock();
        wr(2'd0, 8'h0E);
        c0 = cyc;
        wait_idle(c0, len);
        chk(len == CYC, "R6 busy length directed", len, CYC);
        ref_mem[8'h40] = 8'h77;
        wr(2'd2, 8'h01);
        wr(2'd0, 8'h0E);
        peek(2'd0, v);
        chk(v[1] == 1'b0, "R12 second start ignored", v, 0);
        check_byte(8'h40, "R12 byte kept");

        for (int k = 0; k < 5; k++) bad_write(8'h50 + 8'(k), 8'h00, k);

        // random phase
        for (int it = 0; it < 40; it++) begin
            logic [7:0] a, d;
            int op;
            a  = 8'($urandom);
            d  = 8'($urandom);
            op = int'($urandom % 4);
            unique case (op)
                0: do_write(a, d, 0);
                1: do_write(a, d, 1 + int'($urandom % 2));
                2: bad_write(a, d, int'($urandom % 5));
                default: check_byte(a, "R2 random read");
            endcase
            if (ref_err) begin
                wr(2'd0, 8'h04);
                ref_err = 1'b0;
            end
        end

        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule